// File: doc/BRIEF.md
# Dual-Channel Wiper Register Command Executor

This block carries out the instruction byte received by a two-wire serial front end for a pair of digital potentiometer channels. Each channel owns one volatile 6-bit wiper register, which sets the tap position, and four 6-bit data registers. The data registers model non-volatile storage. The block decodes the operation, the register index and the channel select. It then reads or loads registers, moves values between a data register and a wiper on one channel or on both channels at once, and steps a wiper up or down one tap at a time.

Data registers change only at the stop condition. The change is gated by an active-low write-protect pin, and a store holds a busy flag for a fixed number of clock cycles. The front end uses this flag to refuse new commands. Read results leave on a valid/ready output. The result is held until the consumer takes it, and only a later read instruction replaces it. The inputs that come from the front end are single-cycle strobes and cannot be back-pressured.

Top module: `dpot_cmd_exec`

## Requirements
- R1: After reset, both wipers and all eight data registers hold the parameter `DR_INIT`, which stands in for the recall of data register 0. After reset, `busy`, `rd_valid` and `wiper_upd` are low.
- R2: Instruction byte layout:
  - Bits 7:4 carry the opcode.
  - Bits 3:2 select the data register.
  - Bit 1 is reserved and must be 0.
  - Bit 0 selects the channel.
  - Opcodes: 1001 read wiper, 1010 write wiper, 1011 read data register, 1100 write data register, 1101 data register to wiper, 1110 wiper to data register, 0001 global data registers to wipers, 1000 global wipers to data registers, 0010 step.
- R3: A read instruction raises `rd_valid` in the cycle after its strobe. `rd_data` then holds the selected wiper or data register. Both stay stable until a cycle with `rd_ready` high, after which `rd_valid` is low.
- R4: In a write-wiper command, the first data strobe loads the selected wiper in the following cycle. Any further data strobes before the stop are ignored.
- R5: In a write-data-register command, the first data byte is stored into the selected data register at the stop strobe. `busy` is then high for exactly `BUSY_CYCLES` cycles, starting the cycle after the stop.
- R6: A single data-register-to-wiper transfer loads the wiper in the cycle after the instruction strobe and does not raise `busy`.
- R7: A single wiper-to-data-register transfer stores the wiper value held at the stop strobe and raises `busy` as in R5.
- R8: Global transfers act on both channels with the same register index, and bit 0 is ignored. The load-to-wiper form takes effect at once. The store form takes effect at the stop.
- R9: After a step command, each step strobe moves the selected wiper by one: up when `step_up` is 1, down when it is 0. The wiper saturates at 0 and at 63. Steps stop at the stop strobe.
- R10: If `wp_n` is low at the stop strobe, no data register changes and `busy` stays low.
- R11: While `busy` is high, instruction, data and step strobes have no effect on wipers, registers or `rd_valid`.
- R12: An unknown opcode, or a set reserved bit, changes no register and produces no read. Data and step strobes that follow it are also ignored.
- R13: The bit of `wiper_upd` for a channel is high in the cycle in which a new value of that channel's wiper first appears on `wiper_pos`. A wiper never changes without that bit being high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_vld | input | 1 | Strobe: instruction byte received |
| instr_byte | input | 8 | Instruction byte |
| data_vld | input | 1 | Strobe: third byte received |
| data_val | input | 6 | Third byte payload |
| step_vld | input | 1 | Strobe: one step pulse |
| step_up | input | 1 | Step direction, 1 = toward 63 |
| stop_evt | input | 1 | Strobe: stop condition seen |
| wp_n | input | 1 | Write protect, low blocks stores |
| rd_valid | output | 1 | Read result available |
| rd_ready | input | 1 | Read result taken |
| rd_data | output | 6 | Read result |
| wiper_pos | output | 12 | Wiper positions, channel 1 in bits 11:6 |
| wiper_upd | output | 2 | Per-channel wiper load indication |
| busy | output | 1 | Store in progress |

## Verification
The register model is driven by randomly chosen commands, each with a random channel, register index, payload and write-protect level. Directed cases are mixed in. Step bursts of up to 70 pulses in one direction push the wipers into both saturation limits, which separates correct clamping from wrap-around. Commands with write protect low are compared with the same commands with it high, so a store that ignores the pin shows up. Global transfers are checked on both channels, so a decoder that honours bit 0 for them is caught. Strobes sent during a busy window, extra data bytes, and illegal bytes followed by data and steps each show whether a register changes when it should not.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int POS_W    = 6;
  localparam int DR_N     = 4;
  localparam int DR_IDX_W = $clog2(DR_N);
  localparam int CH_N     = 2;

  typedef enum logic [3:0] {
    OP_NONE, OP_RD_WIPER, OP_WR_WIPER, OP_RD_DR, OP_WR_DR,
    OP_DR2W, OP_W2DR, OP_G_DR2W, OP_G_W2DR, OP_STEP
  } op_e;

  typedef struct packed {
    op_e                 op;
    logic [DR_IDX_W-1:0] idx;
    logic                ch;
  } cmd_t;
endpackage

// File: rtl/dpot_decode.sv
module dpot_decode
  import dpot_pkg::*;
(
  input  logic [7:0] byte_i,
  output cmd_t       cmd_o
);
  always_comb begin
    cmd_o.idx = byte_i[3:2];
    cmd_o.ch  = byte_i[0];
    cmd_o.op  = OP_NONE;
    if (!byte_i[1]) begin
      unique case (byte_i[7:4])
        4'b1001: cmd_o.op = OP_RD_WIPER;
        4'b1010: cmd_o.op = OP_WR_WIPER;
        4'b1011: cmd_o.op = OP_RD_DR;
        4'b1100: cmd_o.op = OP_WR_DR;
        4'b1101: cmd_o.op = OP_DR2W;
        4'b1110: cmd_o.op = OP_W2DR;
        4'b0001: cmd_o.op = OP_G_DR2W;
        4'b1000: cmd_o.op = OP_G_W2DR;
        4'b0010: cmd_o.op = OP_STEP;
        default: cmd_o.op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dpot_nv_timer.sv
module dpot_nv_timer #(
  parameter int BUSY_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= CNT_W'(BUSY_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/dpot_chan_regs.sv
module dpot_chan_regs
  import dpot_pkg::*;
#(
  parameter logic [POS_W-1:0] DR_INIT = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DR_IDX_W-1:0] sel_idx_i,
  input  logic                ld_dr_i,
  input  logic                ld_val_i,
  input  logic [POS_W-1:0]    val_i,
  input  logic                step_i,
  input  logic                up_i,
  input  logic                st_i,
  input  logic [DR_IDX_W-1:0] st_idx_i,
  input  logic [POS_W-1:0]    st_val_i,
  output logic [POS_W-1:0]    rd_dr_o,
  output logic [POS_W-1:0]    wip_o,
  output logic                upd_o
);
  logic [POS_W-1:0] dr_q [DR_N];
  logic [POS_W-1:0] wip_q;
  logic             step_mv;

  assign step_mv = step_i && (up_i ? (wip_q != '1) : (wip_q != '0));
  assign rd_dr_o = dr_q[sel_idx_i];
  assign wip_o   = wip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wip_q <= DR_INIT;
      upd_o <= 1'b0;
      for (int i = 0; i < DR_N; i++) dr_q[i] <= DR_INIT;
    end else begin
      upd_o <= ld_dr_i || ld_val_i || step_mv;
      if (ld_dr_i)       wip_q <= dr_q[sel_idx_i];
      else if (ld_val_i) wip_q <= val_i;
      else if (step_mv)  wip_q <= up_i ? wip_q + 1'b1 : wip_q - 1'b1;
      if (st_i) dr_q[st_idx_i] <= st_val_i;
    end
  end
endmodule

// File: rtl/dpot_cmd_exec.sv
module dpot_cmd_exec
  import dpot_pkg::*;
#(
  parameter int               BUSY_CYCLES = 50000,
  parameter logic [POS_W-1:0] DR_INIT     = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  instr_vld,
  input  logic [7:0]            instr_byte,
  input  logic                  data_vld,
  input  logic [POS_W-1:0]      data_val,
  input  logic                  step_vld,
  input  logic                  step_up,
  input  logic                  stop_evt,
  input  logic                  wp_n,
  output logic                  rd_valid,
  input  logic                  rd_ready,
  output logic [POS_W-1:0]      rd_data,
  output logic [CH_N*POS_W-1:0] wiper_pos,
  output logic [CH_N-1:0]       wiper_upd,
  output logic                  busy
);
  cmd_t                       dec;
  logic                       take;
  op_e                        act_op;
  logic [DR_IDX_W-1:0]        act_idx;
  logic                       act_ch;
  logic                       got_data;
  logic [POS_W-1:0]           pend_q;
  logic [CH_N-1:0][POS_W-1:0] wip_a;
  logic [CH_N-1:0][POS_W-1:0] drrd_a;
  logic [CH_N-1:0]            store_v;
  logic                       first_data;

  dpot_decode u_dec (.byte_i(instr_byte), .cmd_o(dec));

  assign take       = instr_vld && !busy;
  assign first_data = data_vld && !got_data &&
                      (act_op == OP_WR_WIPER || act_op == OP_WR_DR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_op   <= OP_NONE;
      act_idx  <= '0;
      act_ch   <= 1'b0;
      got_data <= 1'b0;
      pend_q   <= '0;
    end else if (take) begin
      act_op   <= dec.op;
      act_idx  <= dec.idx;
      act_ch   <= dec.ch;
      got_data <= 1'b0;
    end else if (stop_evt) begin
      act_op   <= OP_NONE;
      got_data <= 1'b0;
    end else if (first_data) begin
      got_data <= 1'b1;
      pend_q   <= data_val;
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic mine_new, mine_act, ld_dr, ld_val, stp, st;
    assign mine_new = (dec.ch == 1'(c));
    assign mine_act = (act_ch == 1'(c));
    assign ld_dr  = take && ((dec.op == OP_DR2W && mine_new) || dec.op == OP_G_DR2W);
    assign ld_val = first_data && act_op == OP_WR_WIPER && mine_act;
    assign stp    = step_vld && act_op == OP_STEP && mine_act;
    assign st     = stop_evt && wp_n && !busy && !take &&
                    ((act_op == OP_WR_DR && got_data && mine_act) ||
                     (act_op == OP_W2DR && mine_act) ||
                     (act_op == OP_G_W2DR));
    assign store_v[c] = st;

    dpot_chan_regs #(.DR_INIT(DR_INIT)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_idx_i(dec.idx),
      .ld_dr_i  (ld_dr),
      .ld_val_i (ld_val),
      .val_i    (data_val),
      .step_i   (stp),
      .up_i     (step_up),
      .st_i     (st),
      .st_idx_i (act_idx),
      .st_val_i (act_op == OP_WR_DR ? pend_q : wip_a[c]),
      .rd_dr_o  (drrd_a[c]),
      .wip_o    (wip_a[c]),
      .upd_o    (wiper_upd[c])
    );
    assign wiper_pos[c*POS_W +: POS_W] = wip_a[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (take && (dec.op == OP_RD_WIPER || dec.op == OP_RD_DR)) begin
      rd_valid <= 1'b1;
      rd_data  <= (dec.op == OP_RD_WIPER) ? wip_a[dec.ch] : drrd_a[dec.ch];
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  dpot_nv_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(|store_v),
    .busy_o (busy)
  );
endmodule

// File: rtl/dpot_exec_chk.sv
module dpot_exec_chk
  import dpot_pkg::*;
#(
  parameter int BUSY_CYCLES = 50000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  instr_vld,
  input logic                  stop_evt,
  input logic                  wp_n,
  input logic                  rd_valid,
  input logic                  rd_ready,
  input logic [POS_W-1:0]      rd_data,
  input logic [CH_N*POS_W-1:0] wiper_pos,
  input logic [CH_N-1:0]       wiper_upd,
  input logic                  busy
);
  int unsigned run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_q < BUSY_CYCLES); // R5

  AST_BUSY_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt) && $past(wp_n)); // R10

  AST_BUSY_FREEZES_WIPERS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wiper_pos)); // R11

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !instr_vld) |=> rd_valid && $stable(rd_data)); // R3

  AST_CH0_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper_pos[POS_W-1:0] != $past(wiper_pos[POS_W-1:0])) |-> wiper_upd[0]); // R13

  AST_CH1_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper_pos[2*POS_W-1:POS_W] != $past(wiper_pos[2*POS_W-1:POS_W])) |-> wiper_upd[1]); // R13
endmodule

bind dpot_cmd_exec dpot_exec_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .stop_evt(stop_evt),
  .wp_n(wp_n), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .wiper_pos(wiper_pos), .wiper_upd(wiper_upd), .busy(busy)
);

// File: tb/sim_dpot_cmd_exec.sv
`timescale 1ns/1ps
module sim_dpot_cmd_exec;
  localparam int        CYC  = 20;
  localparam logic [5:0] INIT = 6'd21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_vld = 0, data_vld = 0, step_vld = 0, step_up = 0, stop_evt = 0;
  logic wp_n = 1, rd_ready = 0;
  logic [7:0] instr_byte = '0;
  logic [5:0] data_val = '0;
  logic rd_valid, busy;
  logic [5:0] rd_data;
  logic [11:0] wiper_pos;
  logic [1:0] wiper_upd;

  int n_chk = 0, n_bad = 0;
  logic [5:0] mw [2];
  logic [5:0] md [2][4];

  always #2.5 clk = ~clk;

  dpot_cmd_exec #(.BUSY_CYCLES(CYC), .DR_INIT(INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr_byte(instr_byte),
    .data_vld(data_vld), .data_val(data_val), .step_vld(step_vld),
    .step_up(step_up), .stop_evt(stop_evt), .wp_n(wp_n), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .wiper_pos(wiper_pos),
    .wiper_upd(wiper_upd), .busy(busy));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic [3:0] op, input int idx, input int ch);
    return {op, 2'(idx), 1'b0, 1'(ch)};
  endfunction

  function automatic logic [5:0] stepped(input logic [5:0] v, input logic up);
    if (up) return (v == 6'd63) ? v : v + 6'd1;
    return (v == 6'd0) ? v : v - 6'd1;
  endfunction

  task automatic p_instr(input logic [7:0] b);
    instr_byte = b; instr_vld = 1; @(negedge clk); instr_vld = 0;
  endtask
  task automatic p_data(input logic [5:0] d);
    data_val = d; data_vld = 1; @(negedge clk); data_vld = 0;
  endtask
  task automatic p_step(input logic up);
    step_up = up; step_vld = 1; @(negedge clk); step_vld = 0;
  endtask
  task automatic p_take;
    rd_ready = 1; @(negedge clk); rd_ready = 0;
  endtask

  // stop, then measure the busy window length
  task automatic p_stop(input string req, input bit expect_store);
    int n;
    stop_evt = 1; @(negedge clk); stop_evt = 0;
    n = 0;
    while (busy && n < 10 * CYC) begin n++; @(negedge clk); end
    chk(req, n, expect_store ? CYC : 0);
  endtask

  task automatic chk_wipers(input string req);
    chk({req, " wiper0"}, int'(wiper_pos[5:0]), int'(mw[0]));
    chk({req, " wiper1"}, int'(wiper_pos[11:6]), int'(mw[1]));
  endtask

  task automatic rd_check(input string req, input logic [7:0] b, input logic [5:0] exp);
    p_instr(b);
    chk({req, " rd_valid"}, int'(rd_valid), 1);
    chk({req, " rd_data"}, int'(rd_data), int'(exp));
    @(negedge clk);
    chk({req, " rd_data held"}, int'(rd_data), int'(exp));
    p_take;
    chk({req, " rd_valid cleared"}, int'(rd_valid), 0);
    p_stop(req, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd7741);
    for (int c = 0; c < 2; c++) begin
      mw[c] = INIT;
      for (int i = 0; i < 4; i++) md[c][i] = INIT;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", int'(wiper_pos[5:0]), int'(INIT));
    chk("R1", int'(wiper_pos[11:6]), int'(INIT));
    chk("R1 busy", int'(busy), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 upd", int'(wiper_upd), 0);
    rst_n = 1;
    @(negedge clk);
    rd_check("R1 R3 dr", mk(4'b1011, 3, 1), INIT);

    // R4: write wiper, second byte ignored; R13 pulse
    p_instr(mk(4'b1010, 0, 1));
    p_data(6'd40);
    chk("R13 upd", int'(wiper_upd), 2);
    p_data(6'd9);
    chk("R13 upd low", int'(wiper_upd), 0);
    p_stop("R4", 0);
    mw[1] = 6'd40;
    chk_wipers("R4");

    // R5 write DR, then R6 transfer back
    p_instr(mk(4'b1100, 2, 0));
    p_data(6'd55);
    p_stop("R5 busy", 1);
    md[0][2] = 6'd55;
    p_instr(mk(4'b1101, 2, 0));
    chk("R6 immediate", int'(wiper_pos[5:0]), 55);
    chk("R6 busy", int'(busy), 0);
    p_stop("R6", 0);
    mw[0] = 6'd55;

    // R11: strobes during busy ignored
    p_instr(mk(4'b1110, 1, 0));
    stop_evt = 1; @(negedge clk); stop_evt = 0;
    md[0][1] = mw[0];
    chk("R11 busy up", int'(busy), 1);
    p_instr(mk(4'b1010, 0, 0));
    p_data(6'd3);
    p_instr(mk(4'b0010, 0, 1));
    p_step(1'b1);
    p_instr(mk(4'b1001, 0, 0));
    chk("R11 no read", int'(rd_valid), 0);
    while (busy) @(negedge clk);
    chk_wipers("R11");
    rd_check("R7 R11", mk(4'b1011, 1, 0), md[0][1]);

    // R10: write protect
    wp_n = 0;
    p_instr(mk(4'b1100, 3, 1));
    p_data(6'd1);
    p_stop("R10 no busy", 0);
    wp_n = 1;
    rd_check("R10 unchanged", mk(4'b1011, 3, 1), md[1][3]);

    // R12: reserved bit set, then data/steps
    p_instr(8'b1010_0011);
    p_data(6'd2);
    p_instr(8'b0010_0010);
    p_step(1'b0);
    p_stop("R12", 0);
    chk_wipers("R12");

    // randomized mix
    for (int it = 0; it < 300; it++) begin
      int k, ch, idx, n;
      logic up;
      logic [5:0] d;
      k = $urandom % 10; ch = $urandom % 2; idx = $urandom % 4; d = 6'($urandom);
      wp_n = ($urandom % 4) != 0;
      case (k)
        0: rd_check("R3 rand wiper", mk(4'b1001, idx, ch), mw[ch]);
        1: rd_check("R3 rand dr", mk(4'b1011, idx, ch), md[ch][idx]);
        2: begin
          p_instr(mk(4'b1010, idx, ch)); p_data(d);
          if ($urandom % 2) p_data(~d);
          p_stop("R4 rand", 0); mw[ch] = d;
        end
        3: begin
          p_instr(mk(4'b1100, idx, ch)); p_data(d);
          if (wp_n) md[ch][idx] = d;
          p_stop("R5 R10 rand", wp_n);
        end
        4: begin
          p_instr(mk(4'b1101, idx, ch)); mw[ch] = md[ch][idx];
          p_stop("R6 rand", 0);
        end
        5: begin
          p_instr(mk(4'b1110, idx, ch));
          if (wp_n) md[ch][idx] = mw[ch];
          p_stop("R7 rand", wp_n);
        end
        6: begin
          p_instr(mk(4'b0001, idx, ch));
          mw[0] = md[0][idx]; mw[1] = md[1][idx];
          p_stop("R8 rand load", 0);
        end
        7: begin
          p_instr(mk(4'b1000, idx, ch));
          if (wp_n) begin md[0][idx] = mw[0]; md[1][idx] = mw[1]; end
          p_stop("R8 rand store", wp_n);
        end
        8: begin
          p_instr(mk(4'b0010, 0, ch));
          up = $urandom % 2; n = 1 + $urandom % 70;
          for (int s = 0; s < n; s++) begin p_step(up); mw[ch] = stepped(mw[ch], up); end
          p_stop("R9 rand", 0);
          p_step(~up);
        end
        default: begin
          if ($urandom % 2) p_instr({4'b1111, 2'(idx), 1'b0, 1'(ch)});
          else p_instr({4'b1100, 2'(idx), 1'b1, 1'(ch)});
          p_data(d); p_step(1'b1);
          p_stop("R12 rand", 0);
          chk("R12 rand no read", int'(rd_valid), 0);
        end
      endcase
      chk_wipers("R2 rand");
    end
    wp_n = 1;
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 4; i++) rd_check("R2 final dr", mk(4'b1011, i, c), md[c][i]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule